// File: doc/BRIEF.md
# CPU exception entry controller

This block carries out exception and interrupt entry for a simple privileged CPU. The pipeline raises a one-cycle trap request with a major cause code, a subcode, the PC of the trapping instruction and that instruction's word. At the clock edge that samples the request, the unit updates its control and status state in one step: current mode, the saved previous mode, the exception status, the return addresses, the bad address, the bad instruction and the debug state. In the next cycle it presents the new fetch address together with a one-cycle redirect strobe.

There are three entry paths, and each one saves into its own registers. The debug path goes to a fixed offset from the exception base. The refill path is taken while a translation refill is in progress. It forces direct-address mode and jumps to a separate refill base. The normal path covers everything else. Interrupts are vectored. The vector is the highest set bit of the pending-and-enabled mask, and the spacing between vectors is programmable. A separate combinational output tells the pipeline whether a hardware interrupt may be taken now. A mode-load port restores the current mode and the debug-active bit, standing in for the return path.

The controller is a three-state machine. `S_IDLE` is the resting state. `S_REDIRECT` means an entry was committed, and `S_REJECT` means the cause code was unsupported. Any state moves to `S_REDIRECT` on a supported request (transition "accept"), to `S_REJECT` on an unsupported one (transition "reject"), and to `S_IDLE` otherwise (transition "settle").

Top module: `trap_entry_ctrl`

## Requirements
- R1: Supported causes (major/sub) are: 0 interrupt, 1 load page-invalid, 2 store page-invalid, 3 fetch page-invalid, 4 page-modified, 5 not-readable, 6 not-executable, 7 privilege-page, 8 address error (sub 0 fetch, sub 1 memory), 10 bound check, 11 syscall, 12 break, 13 undefined instruction, 14 privileged instruction, 15 FP disabled, 16 128-bit vector disabled, 17 256-bit vector disabled, 18 FP exception and 26 debug breakpoint. Every cause other than 8 must have subcode 0. Any other code pulses `cause_err` for one cycle, leaves `redirect` low and changes no register and not `new_pc`.
- R2: For a supported request sampled at edge k, all register updates become visible after edge k. `redirect` is high for exactly the following cycle, and `new_pc` carries the target in that cycle.
- R3: Every accepted entry forces the current privilege level to 0 and the interrupt enable to 0.
- R4: A normal (non-debug, non-refill) entry writes the major code and subcode into the status fields, saves the privilege level and interrupt enable into the previous-mode fields, and writes the PC into `era`.
- R5: A refill entry (`refill_active`=1, non-debug) saves the privilege level and interrupt enable into the refill previous-mode fields, sets direct-address mode to 1 and paging to 0, and writes PC>>2 into `rera_pc`. It leaves the status fields and `era` unchanged. For non-interrupt causes the target is `refill_base`.
- R6: The vector spacing is (1<<`vec_sel`)*4 bytes when `vec_sel` is nonzero and 0 when it is zero.
- R7: A non-interrupt normal entry targets `eentry` + major*spacing.
- R8: An interrupt entry targets `eentry` + (64+v)*spacing, where v is the index of the highest set bit of `irq_pend & irq_en` (v=0 if none is set).
- R9: Causes 11 to 18 write the PC into `badv`. Other causes leave it unchanged.
- R10: Interrupts, fetch page-invalid (3) and fetch address error (8/0) leave `badi` unchanged. Every other non-debug entry captures the instruction word.
- R11: A debug breakpoint (26) sets `dbg_dcl`, writes 0xC into `dbg_ecode`, copies the PC into `dera`, sets `dbg_dst` and targets `eentry`+0x480. The normal and refill save registers are untouched.
- R12: An interrupt request while `dbg_dst`=1 sets `dbg_dei`, copies the PC into `dera`, targets `eentry`+0x480, and leaves the status fields and `era` unchanged.
- R13: `irq_take` is 1 only when the interrupt enable is 1, `dbg_dst` is 0 and `irq_pend & irq_en` is nonzero.
- R14: A `mode_ld` pulse loads the privilege level, interrupt enable, direct-address, paging and debug-active bits. After reset these are 0, 0, 1, 0, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_major | input | 6 | Major cause code |
| trap_sub | input | 9 | Cause subcode |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_inst | input | 32 | Instruction word at that PC |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Local interrupt enables |
| vec_sel | input | 3 | Vector spacing select |
| eentry | input | 32 | Exception entry base (64-byte aligned) |
| refill_base | input | 32 | Refill entry base |
| refill_active | input | 1 | Translation refill in progress |
| mode_ld | input | 1 | Load current mode from the ld_* inputs |
| ld_plv | input | 2 | Privilege level to load |
| ld_ie | input | 1 | Interrupt enable to load |
| ld_da | input | 1 | Direct-address bit to load |
| ld_pg | input | 1 | Paging bit to load |
| ld_dst | input | 1 | Debug-active bit to load |
| irq_take | output | 1 | Hardware interrupt may be taken |
| redirect | output | 1 | New PC valid (one cycle) |
| new_pc | output | 32 | Entry target address |
| cause_err | output | 1 | Unsupported cause rejected (one cycle) |
| crmd_plv | output | 2 | Current privilege level |
| crmd_ie | output | 1 | Current interrupt enable |
| crmd_da | output | 1 | Direct-address mode |
| crmd_pg | output | 1 | Paging mode |
| prmd_plv | output | 2 | Saved privilege level (normal) |
| prmd_ie | output | 1 | Saved interrupt enable (normal) |
| rprmd_plv | output | 2 | Saved privilege level (refill) |
| rprmd_ie | output | 1 | Saved interrupt enable (refill) |
| stat_code | output | 6 | Recorded major code |
| stat_sub | output | 9 | Recorded subcode |
| era | output | 32 | Normal return address |
| rera_pc | output | 30 | Refill return address (PC>>2) |
| badv | output | 32 | Bad virtual address |
| badi | output | 32 | Bad instruction word |
| dera | output | 32 | Debug return address |
| dbg_dst | output | 1 | Debug mode active |
| dbg_dcl | output | 1 | Debug breakpoint cause latched |
| dbg_dei | output | 1 | Debug interrupt taken |
| dbg_ecode | output | 6 | Debug exception code |

## Verification
A request driven in one cycle is sampled at the next rising edge. From there, the saved state, `new_pc` and `redirect` (or `cause_err`) are due in the cycle that follows. The bench reads them at the falling edge of that cycle and checks at the next falling edge that the strobe has dropped. `irq_take` is combinational on the stored mode and the interrupt inputs, so it is checked one falling edge after a `mode_ld` pulse or a change of the interrupt inputs. Registers that a scenario must leave untouched are compared against the value the bench recorded from the earlier scenario that last wrote them.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
    localparam int XLEN = 32;
    localparam int MAJW = 6;
    localparam int SUBW = 9;

    localparam logic [MAJW-1:0] C_INT   = 6'd0;
    localparam logic [MAJW-1:0] C_PIF   = 6'd3;
    localparam logic [MAJW-1:0] C_ADE   = 6'd8;
    localparam logic [MAJW-1:0] C_BCE   = 6'd10;
    localparam logic [MAJW-1:0] C_SYS   = 6'd11;
    localparam logic [MAJW-1:0] C_FPE   = 6'd18;
    localparam logic [MAJW-1:0] C_DBP   = 6'd26;
    localparam logic [MAJW-1:0] DBG_CODE = 6'hC;
    localparam int IRQ_CODE_BASE = 64;

    typedef struct packed {
        logic valid;
        logic is_irq;
        logic is_dbp;
        logic wr_badv;
        logic keep_badi;
    } cause_info_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REDIRECT,
        S_REJECT
    } entry_state_t;
endpackage

// File: rtl/trap_cause_class.sv
module trap_cause_class
    import trap_entry_pkg::*;
(
    input  logic [MAJW-1:0] major,
    input  logic [SUBW-1:0] sub,
    output cause_info_t     info
);
    logic sub_zero;
    assign sub_zero = (sub == '0);

    always_comb begin
        info = '0;
        if (major == C_INT) begin
            info.valid     = sub_zero;
            info.is_irq    = 1'b1;
            info.keep_badi = 1'b1;
        end else if (major <= 6'd7) begin
            info.valid     = sub_zero;
            info.keep_badi = (major == C_PIF);
        end else if (major == C_ADE) begin
            info.valid     = (sub <= 9'd1);
            info.keep_badi = (sub == '0);
        end else if (major == C_BCE) begin
            info.valid     = sub_zero;
        end else if (major >= C_SYS && major <= C_FPE) begin
            info.valid     = sub_zero;
            info.wr_badv   = 1'b1;
        end else if (major == C_DBP) begin
            info.valid     = sub_zero;
            info.is_dbp    = 1'b1;
        end
    end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
    import trap_entry_pkg::*;
#(
    parameter int NIRQ = 13,
    parameter int VSW  = 3
) (
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] en,
    input  logic [VSW-1:0]  vs,
    input  logic [XLEN-1:0] base,
    input  logic [MAJW-1:0] major,
    input  logic            is_irq,
    output logic            any_irq,
    output logic [XLEN-1:0] target
);
    localparam int VIDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [NIRQ-1:0]  live;
    logic [VIDXW-1:0] vec;
    logic [XLEN-1:0]  idx;

    assign live    = pend & en;
    assign any_irq = |live;

    always_comb begin
        vec = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (live[i]) vec = VIDXW'(i);
        end
    end

    always_comb begin
        if (is_irq) idx = XLEN'(IRQ_CODE_BASE) + XLEN'(vec);
        else        idx = XLEN'(major);
        if (vs == '0) target = base;
        else          target = base + (idx << (XLEN'(vs) + 2));
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int          NIRQ    = 13,
    parameter int          VSW     = 3,
    parameter logic [31:0] DBG_OFS = 32'h480
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [5:0]      trap_major,
    input  logic [8:0]      trap_sub,
    input  logic [31:0]     trap_pc,
    input  logic [31:0]     trap_inst,
    input  logic [NIRQ-1:0] irq_pend,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [VSW-1:0]  vec_sel,
    input  logic [31:0]     eentry,
    input  logic [31:0]     refill_base,
    input  logic            refill_active,
    input  logic            mode_ld,
    input  logic [1:0]      ld_plv,
    input  logic            ld_ie,
    input  logic            ld_da,
    input  logic            ld_pg,
    input  logic            ld_dst,
    output logic            irq_take,
    output logic            redirect,
    output logic [31:0]     new_pc,
    output logic            cause_err,
    output logic [1:0]      crmd_plv,
    output logic            crmd_ie,
    output logic            crmd_da,
    output logic            crmd_pg,
    output logic [1:0]      prmd_plv,
    output logic            prmd_ie,
    output logic [1:0]      rprmd_plv,
    output logic            rprmd_ie,
    output logic [5:0]      stat_code,
    output logic [8:0]      stat_sub,
    output logic [31:0]     era,
    output logic [29:0]     rera_pc,
    output logic [31:0]     badv,
    output logic [31:0]     badi,
    output logic [31:0]     dera,
    output logic            dbg_dst,
    output logic            dbg_dcl,
    output logic            dbg_dei,
    output logic [5:0]      dbg_ecode
);
    cause_info_t  info;
    entry_state_t state_q, state_d;
    logic         any_irq;
    logic [31:0]  vec_target;
    logic         take, dbg_path, refill_path, norm_path, save_path;
    logic [31:0]  target;

    trap_cause_class u_class (
        .major (trap_major),
        .sub   (trap_sub),
        .info  (info)
    );

    trap_vec_gen #(.NIRQ(NIRQ), .VSW(VSW)) u_vec (
        .pend    (irq_pend),
        .en      (irq_en),
        .vs      (vec_sel),
        .base    (eentry),
        .major   (trap_major),
        .is_irq  (info.is_irq),
        .any_irq (any_irq),
        .target  (vec_target)
    );

    assign irq_take = crmd_ie && !dbg_dst && any_irq;

    // path selection
    assign take        = trap_req && info.valid;
    assign dbg_path    = take && (info.is_dbp || (info.is_irq && dbg_dst));
    assign save_path   = take && !dbg_path;
    assign refill_path = save_path && refill_active;
    assign norm_path   = save_path && !refill_active;

    always_comb begin
        if (dbg_path)                         target = eentry + DBG_OFS;
        else if (refill_path && !info.is_irq) target = refill_base;
        else                                  target = vec_target;
    end

    // next-state process
    always_comb begin
        unique case (state_q)
            S_IDLE, S_REDIRECT, S_REJECT: begin
                if (take)          state_d = S_REDIRECT;
                else if (trap_req) state_d = S_REJECT;
                else               state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign redirect  = (state_q == S_REDIRECT);
    assign cause_err = (state_q == S_REJECT);

    // output and control/status register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_pc    <= '0;
            crmd_plv  <= 2'd0;
            crmd_ie   <= 1'b0;
            crmd_da   <= 1'b1;
            crmd_pg   <= 1'b0;
            prmd_plv  <= '0;
            prmd_ie   <= 1'b0;
            rprmd_plv <= '0;
            rprmd_ie  <= 1'b0;
            stat_code <= '0;
            stat_sub  <= '0;
            era       <= '0;
            rera_pc   <= '0;
            badv      <= '0;
            badi      <= '0;
            dera      <= '0;
            dbg_dst   <= 1'b0;
            dbg_dcl   <= 1'b0;
            dbg_dei   <= 1'b0;
            dbg_ecode <= '0;
        end else if (take) begin
            new_pc   <= target;
            crmd_plv <= 2'd0;
            crmd_ie  <= 1'b0;
            if (dbg_path) begin
                dera    <= trap_pc;
                dbg_dst <= 1'b1;
                if (info.is_dbp) begin
                    dbg_dcl   <= 1'b1;
                    dbg_ecode <= DBG_CODE;
                end else begin
                    dbg_dei <= 1'b1;
                end
            end
            if (save_path) begin
                if (info.wr_badv)    badv <= trap_pc;
                if (!info.keep_badi) badi <= trap_inst;
            end
            if (refill_path) begin
                rprmd_plv <= crmd_plv;
                rprmd_ie  <= crmd_ie;
                crmd_da   <= 1'b1;
                crmd_pg   <= 1'b0;
                rera_pc   <= trap_pc[31:2];
            end
            if (norm_path) begin
                stat_code <= trap_major;
                stat_sub  <= trap_sub;
                prmd_plv  <= crmd_plv;
                prmd_ie   <= crmd_ie;
                era       <= trap_pc;
            end
        end else if (mode_ld && !trap_req) begin
            crmd_plv <= ld_plv;
            crmd_ie  <= ld_ie;
            crmd_da  <= ld_da;
            crmd_pg  <= ld_pg;
            dbg_dst  <= ld_dst;
        end
    end

    // R2: redirect only follows a request
    p_redirect_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(trap_req));

    // R3: every entry leaves privilege 0 and interrupts off
    p_mode_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (crmd_plv == 2'd0 && !crmd_ie));

    // R1: a rejected cause changes nothing
    p_reject_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cause_err |-> ($stable(era) && $stable(new_pc) && $stable(badi) && $stable(dera)));

    // R11: debug breakpoint enters debug mode at the fixed offset
    p_debug_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && $past(trap_major) == C_DBP) |->
            (dbg_dst && dbg_dcl && new_pc == $past(eentry) + DBG_OFS));

    // R13: no interrupt acceptance while debug mode is active
    p_irq_blocked_r13: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_dst |-> !irq_take);

    // R5: refill entry forces direct-address mode
    p_refill_da_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && $past(refill_active) && $past(trap_major) != C_DBP && !$past(dbg_dst))
            |-> (crmd_da && !crmd_pg));
endmodule

// File: tb/test_trap_entry_ctrl.sv
module test_trap_entry_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NIRQ = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 1'b0;
    logic [5:0] trap_major = '0;
    logic [8:0] trap_sub = '0;
    logic [31:0] trap_pc = '0, trap_inst = '0;
    logic [NIRQ-1:0] irq_pend = '0, irq_en = '0;
    logic [2:0] vec_sel = '0;
    logic [31:0] eentry = 32'h1000_0000;
    logic [31:0] refill_base = 32'h2000_0040;
    logic refill_active = 1'b0;
    logic mode_ld = 1'b0;
    logic [1:0] ld_plv = '0;
    logic ld_ie = 1'b0, ld_da = 1'b0, ld_pg = 1'b0, ld_dst = 1'b0;
    logic irq_take, redirect, cause_err;
    logic [31:0] new_pc;
    logic [1:0] crmd_plv, prmd_plv, rprmd_plv;
    logic crmd_ie, crmd_da, crmd_pg, prmd_ie, rprmd_ie;
    logic [5:0] stat_code, dbg_ecode;
    logic [8:0] stat_sub;
    logic [31:0] era, badv, badi, dera;
    logic [29:0] rera_pc;
    logic dbg_dst, dbg_dcl, dbg_dei;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_badi, exp_badv, exp_era;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_ctrl #(.NIRQ(NIRQ)) i_trap_entry_ctrl (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic load_mode(input logic [1:0] p, input logic ie, input logic da,
                             input logic pg, input logic dst);
        @(negedge clk);
        mode_ld = 1'b1; ld_plv = p; ld_ie = ie; ld_da = da; ld_pg = pg; ld_dst = dst;
        @(negedge clk);
        mode_ld = 1'b0;
    endtask

    // drives one request; returns at the negedge where results are due
    task automatic fire(input logic [5:0] maj, input logic [8:0] sb,
                        input logic [31:0] pc, input logic [31:0] inst);
        @(negedge clk);
        trap_req = 1'b1; trap_major = maj; trap_sub = sb; trap_pc = pc; trap_inst = inst;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R14 reset plv", 32'(crmd_plv), 0);
        chk("R14 reset ie", 32'(crmd_ie), 0);
        chk("R14 reset da", 32'(crmd_da), 1);
        chk("R14 reset pg", 32'(crmd_pg), 0);
        chk("R14 reset dst", 32'(dbg_dst), 0);
        chk("R2 reset redirect", 32'(redirect), 0);
        chk("R1 reset err", 32'(cause_err), 0);
        chk("R13 reset take", 32'(irq_take), 0);
    endtask

    task automatic t_syscall;
        load_mode(2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R14 loaded plv", 32'(crmd_plv), 3);
        vec_sel = 3'd1;
        fire(6'd11, 9'd0, 32'h0000_4004, 32'hCAFE_0001);
        chk("R2 redirect high", 32'(redirect), 1);
        chk("R7 syscall target", new_pc, 32'h1000_0058);
        chk("R4 stat code", 32'(stat_code), 11);
        chk("R4 prmd plv", 32'(prmd_plv), 3);
        chk("R4 prmd ie", 32'(prmd_ie), 1);
        chk("R4 era", era, 32'h0000_4004);
        chk("R9 badv written", badv, 32'h0000_4004);
        chk("R10 badi captured", badi, 32'hCAFE_0001);
        chk("R3 plv cleared", 32'(crmd_plv), 0);
        chk("R3 ie cleared", 32'(crmd_ie), 0);
        exp_badi = 32'hCAFE_0001; exp_badv = 32'h0000_4004;
        @(negedge clk);
        chk("R2 redirect one cycle", 32'(redirect), 0);
    endtask

    task automatic t_fetch_causes;
        vec_sel = 3'd0;
        fire(6'd3, 9'd0, 32'h0000_5000, 32'h1111_1111);
        chk("R6 spacing zero", new_pc, 32'h1000_0000);
        chk("R10 fetch page keeps badi", badi, exp_badi);
        chk("R9 fetch page keeps badv", badv, exp_badv);
        vec_sel = 3'd3;
        fire(6'd8, 9'd1, 32'h0000_5010, 32'h2222_2222);
        chk("R7 address error target", new_pc, 32'h1000_0100);
        chk("R4 subcode", 32'(stat_sub), 1);
        chk("R10 memory addr err badi", badi, 32'h2222_2222);
        exp_badi = 32'h2222_2222;
        fire(6'd8, 9'd0, 32'h0000_5020, 32'h3333_3333);
        chk("R10 fetch addr err keeps badi", badi, exp_badi);
        vec_sel = 3'd7;
        fire(6'd17, 9'd0, 32'h0000_5030, 32'h4444_4444);
        chk("R6 spacing 512", new_pc, 32'h1000_2200);
        exp_badi = 32'h4444_4444; exp_badv = 32'h0000_5030; exp_era = 32'h0000_5030;
    endtask

    task automatic t_refill;
        load_mode(2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
        refill_active = 1'b1;
        fire(6'd1, 9'd0, 32'h0000_600C, 32'h5555_5555);
        chk("R5 refill target", new_pc, 32'h2000_0040);
        chk("R5 rprmd plv", 32'(rprmd_plv), 2);
        chk("R5 rprmd ie", 32'(rprmd_ie), 1);
        chk("R5 da set", 32'(crmd_da), 1);
        chk("R5 pg clear", 32'(crmd_pg), 0);
        chk("R5 rera", 32'(rera_pc), 32'h0000_1803);
        chk("R5 era untouched", era, exp_era);
        chk("R5 stat untouched", 32'(stat_code), 17);
        refill_active = 1'b0;
        exp_badi = 32'h5555_5555;
    endtask

    task automatic t_interrupt;
        load_mode(2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
        irq_pend = 13'h1025; irq_en = 13'h0000;
        @(negedge clk);
        chk("R13 no enabled line", 32'(irq_take), 0);
        irq_en = 13'h0025;
        @(negedge clk);
        chk("R13 take allowed", 32'(irq_take), 1);
        vec_sel = 3'd2;
        fire(6'd0, 9'd0, 32'h0000_7000, 32'h6666_6666);
        chk("R8 vector target", new_pc, 32'h1000_0450);
        chk("R4 irq code", 32'(stat_code), 0);
        chk("R4 irq era", era, 32'h0000_7000);
        chk("R10 irq keeps badi", badi, exp_badi);
        chk("R13 ie cleared blocks", 32'(irq_take), 0);
    endtask

    task automatic t_debug;
        fire(6'd26, 9'd0, 32'h0000_8000, 32'h7777_7777);
        chk("R11 target", new_pc, 32'h1000_0480);
        chk("R11 dcl", 32'(dbg_dcl), 1);
        chk("R11 ecode", 32'(dbg_ecode), 32'hC);
        chk("R11 dera", dera, 32'h0000_8000);
        chk("R11 dst", 32'(dbg_dst), 1);
        chk("R11 era untouched", era, 32'h0000_7000);
        chk("R11 badi untouched", badi, exp_badi);
        load_mode(2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R13 debug blocks take", 32'(irq_take), 0);
        fire(6'd0, 9'd0, 32'h0000_9000, 32'h8888_8888);
        chk("R12 target", new_pc, 32'h1000_0480);
        chk("R12 dei", 32'(dbg_dei), 1);
        chk("R12 dera", dera, 32'h0000_9000);
        chk("R12 era untouched", era, 32'h0000_7000);
        chk("R12 redirect", 32'(redirect), 1);
    endtask

    task automatic t_reject;
        load_mode(2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
        fire(6'd9, 9'd0, 32'h0000_A000, 32'h9999_9999);
        chk("R1 code 9 err", 32'(cause_err), 1);
        chk("R1 no redirect", 32'(redirect), 0);
        chk("R1 pc held", new_pc, 32'h1000_0480);
        chk("R1 plv held", 32'(crmd_plv), 3);
        chk("R1 era held", era, 32'h0000_7000);
        @(negedge clk);
        chk("R1 err one cycle", 32'(cause_err), 0);
        fire(6'd18, 9'd1, 32'h0000_A004, 32'h9999_9999);
        chk("R1 bad subcode err", 32'(cause_err), 1);
        fire(6'd40, 9'd0, 32'h0000_A008, 32'h9999_9999);
        chk("R1 code 40 err", 32'(cause_err), 1);
        chk("R1 badi held", badi, exp_badi);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_syscall();
        t_fetch_causes();
        t_refill();
        t_interrupt();
        t_debug();
        t_reject();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R2 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule